// File: doc/BRIEF.md
# Width-Aware Holding Register Access

This block sits between a 32-bit host register port and the byte-wide receive and transmit FIFOs of a serial controller. A read strobe on the receive holding register pulls characters out of the RX FIFO and packs them into the read data word. A write strobe on the transmit holding register unpacks the write data word into characters and pushes them into the TX FIFO. The block itself holds no characters. It only decides how many FIFO entries move on each access and which byte lanes carry them.

Two behaviours are chosen from configuration inputs. In multiple data mode the access size sets the character count: a byte access moves one character and a word access moves four. In single data mode every access moves one character, whatever its size. Single data mode applies when the FIFOs are disabled, when 9-bit characters are configured, or when the protocol selector picks one of the LIN or LON modes. An access that cannot complete in full moves as many characters as it can and reports the shortfall.

Top module: `hold_reg_access`

## Requirements
- R1: `multi_mode` is 1 exactly when `cfg_fifo_en` is 1, `cfg_nine_bit` is 0 and `cfg_proto` is 0. The `cfg_proto` encoding is 0 = plain asynchronous, 1 = LIN master, 2 = LIN slave and 3 = LON.
- R2: In single data mode a read or write moves at most one character, even for a word access. A read returns that character in bits 7:0 and zero in bits 31:8. A write pushes bits 7:0 of `bus_wdata`.
- R3: In multiple data mode, a word read with at least four characters available pops four. The oldest character is returned in bits 7:0 and the following ones in ascending byte lanes.
- R4: In multiple data mode, a word write with at least four free TX entries pushes four characters. Bits 7:0 are pushed first and the other lanes follow in ascending order on `tx_wdata`.
- R5: In multiple data mode a byte access (`bus_word` = 0) moves exactly one character when one is available or there is room for one.
- R6: A read that asks for more characters than `rx_avail` pops only the ones available and returns them in the low lanes with zero in the rest. `rd_underrun` is 1 in the cycle after that read and 0 after any read that is served in full.
- R7: A write that asks for more characters than `tx_room` pushes only the ones that fit and sets `tx_overflow`. The flag stays at 1 until reset.
- R8: `bus_rdata` changes in the cycle after a read strobe and holds its value until the next read.
- R9: After reset, `bus_rdata`, `rd_underrun` and `tx_overflow` are 0.
- R10: `rx_pop` never exceeds `rx_avail` and `tx_push` never exceeds `tx_room`. Without a read strobe `rx_pop` is 0, and without a write strobe `tx_push` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fifo_en | input | 1 | FIFOs enabled |
| cfg_nine_bit | input | 1 | 9-bit character mode |
| cfg_proto | input | 2 | Protocol selector (0 async, 1 LIN master, 2 LIN slave, 3 LON) |
| bus_rd | input | 1 | Read strobe for the receive holding register |
| bus_wr | input | 1 | Write strobe for the transmit holding register |
| bus_word | input | 1 | Access size: 1 = word, 0 = byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rd_underrun | output | 1 | The last read was short |
| tx_overflow | output | 1 | Sticky flag for a short write |
| multi_mode | output | 1 | Multiple data mode active |
| rx_avail | input | 3 | Characters in the RX FIFO, capped at 4 |
| rx_head | input | 32 | The four oldest RX characters, oldest in bits 7:0 |
| rx_pop | output | 3 | Number of RX entries to pop this cycle |
| tx_room | input | 3 | Free TX entries, capped at 4 |
| tx_push | output | 3 | Number of TX entries to push this cycle |
| tx_wdata | output | 32 | Characters to push, first in bits 7:0 |

## Verification
The assertions check on every cycle the limits on how much moves: pops and pushes stay within what the FIFOs report, and nothing moves without a strobe. They also check that single mode and byte accesses never move more than one character, that a full word read in multiple mode pops four, that read data holds between reads, and that the overflow flag is sticky. Only the bench scenarios can show the byte order, the zero fill of short reads, the data pushed on each lane, the mode chosen for each configuration and the timing of the underrun pulse. For these the bench compares the block against its own FIFO model.

// File: rtl/hold_reg_access.sv
module hold_reg_access #(
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_fifo_en,
  input  logic                       cfg_nine_bit,
  input  logic [1:0]                 cfg_proto,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic                       bus_word,
  input  logic [LANES*CW-1:0]        bus_wdata,
  output logic [LANES*CW-1:0]        bus_rdata,
  output logic                       rd_underrun,
  output logic                       tx_overflow,
  output logic                       multi_mode,
  input  logic [$clog2(LANES+1)-1:0] rx_avail,
  input  logic [LANES*CW-1:0]        rx_head,
  output logic [$clog2(LANES+1)-1:0] rx_pop,
  input  logic [$clog2(LANES+1)-1:0] tx_room,
  output logic [$clog2(LANES+1)-1:0] tx_push,
  output logic [LANES*CW-1:0]        tx_wdata
);
  localparam int DW = LANES * CW;
  localparam int NW = $clog2(LANES + 1);
  localparam logic [NW-1:0] FULL = NW'(LANES);
  localparam logic [NW-1:0] ONE  = NW'(1);

  logic [NW-1:0] want;
  logic [DW-1:0] rd_pack;

  assign multi_mode = cfg_fifo_en && !cfg_nine_bit && (cfg_proto == 2'd0);
  assign want       = (multi_mode && bus_word) ? FULL : ONE;

  assign rx_pop  = !bus_rd ? '0 : ((rx_avail < want) ? rx_avail : want);
  assign tx_push = !bus_wr ? '0 : ((tx_room  < want) ? tx_room  : want);
  assign tx_wdata = bus_wdata;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rd_pack[i*CW +: CW] = (NW'(i) < rx_pop) ? rx_head[i*CW +: CW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      rd_underrun <= 1'b0;
      tx_overflow <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_pack;
      rd_underrun <= bus_rd && (rx_pop < want);
      if (bus_wr && (tx_push < want)) tx_overflow <= 1'b1;
    end
  end
endmodule

module hold_reg_access_chk #(
  parameter int LANES = 4,
  parameter int CW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic                       bus_word,
  input logic [LANES*CW-1:0]        bus_rdata,
  input logic                       tx_overflow,
  input logic                       multi_mode,
  input logic [$clog2(LANES+1)-1:0] rx_avail,
  input logic [$clog2(LANES+1)-1:0] rx_pop,
  input logic [$clog2(LANES+1)-1:0] tx_room,
  input logic [$clog2(LANES+1)-1:0] tx_push
);
  localparam int NW = $clog2(LANES + 1);

  p_single_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_mode |-> (rx_pop <= NW'(1)) && (tx_push <= NW'(1)));
  p_full_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_word && multi_mode && rx_avail >= NW'(LANES)) |-> rx_pop == NW'(LANES));
  p_byte_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_word |-> (rx_pop <= NW'(1)) && (tx_push <= NW'(1)));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overflow |=> tx_overflow);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  p_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop <= rx_avail) && (tx_push <= tx_room));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd |-> rx_pop == '0) and (!bus_wr |-> tx_push == '0));
endmodule

bind hold_reg_access hold_reg_access_chk #(.LANES(LANES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_rdata(bus_rdata), .tx_overflow(tx_overflow), .multi_mode(multi_mode),
  .rx_avail(rx_avail), .rx_pop(rx_pop), .tx_room(tx_room), .tx_push(tx_push)
);

// File: tb/test_hold_reg_access.sv
`timescale 1ns/1ps
module test_hold_reg_access;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_fifo_en = 1'b1, cfg_nine_bit = 1'b0;
  logic [1:0] cfg_proto = 2'd0;
  logic bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, tx_wdata, rx_head;
  logic rd_underrun, tx_overflow, multi_mode;
  logic [2:0] rx_avail, rx_pop, tx_push;
  logic [2:0] tx_room = 3'd4;
  logic [7:0] rxq [0:15];
  int rx_n = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign rx_avail = (rx_n > 4) ? 3'd4 : 3'(rx_n);
  assign rx_head  = {rxq[3], rxq[2], rxq[1], rxq[0]};

  hold_reg_access i_hold_reg_access (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_nine_bit(cfg_nine_bit),
    .cfg_proto(cfg_proto), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_underrun(rd_underrun),
    .tx_overflow(tx_overflow), .multi_mode(multi_mode), .rx_avail(rx_avail),
    .rx_head(rx_head), .rx_pop(rx_pop), .tx_room(tx_room), .tx_push(tx_push),
    .tx_wdata(tx_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_rx(input logic [31:0] bytes, input int n);
    for (int i = 0; i < 16; i++) rxq[i] = 8'hE0 + 8'(i);
    for (int i = 0; i < 4; i++) rxq[i] = bytes[i*8 +: 8];
    if (n < 4) for (int i = n; i < 4; i++) rxq[i] = 8'hF0 + 8'(i);
    rx_n = n;
  endtask

  task automatic do_read(input logic word, output logic [2:0] popped);
    @(negedge clk);
    bus_rd = 1'b1; bus_word = word;
    #1 popped = rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
    for (int i = 0; i < 12; i++) rxq[i] = rxq[i + int'(popped)];
    rx_n -= int'(popped);
  endtask

  task automatic do_write(input logic word, input logic [31:0] d, output logic [2:0] pushed,
                          output logic [31:0] lanes);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = word; bus_wdata = d;
    #1 pushed = tx_push; lanes = tx_wdata;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 rdata", bus_rdata, 32'h0);
    chk("R9 underrun", {31'h0, rd_underrun}, 32'h0);
    chk("R9 overflow", {31'h0, tx_overflow}, 32'h0);
  endtask

  task automatic t_mode_r1;
    for (int c = 0; c < 16; c++) begin
      cfg_fifo_en = c[3]; cfg_nine_bit = c[2]; cfg_proto = c[1:0];
      #1 chk("R1 mode", {31'h0, multi_mode}, {31'h0, c[3] && !c[2] && c[1:0] == 2'd0});
    end
    cfg_fifo_en = 1'b1; cfg_nine_bit = 1'b0; cfg_proto = 2'd0;
  endtask

  task automatic t_word_read_r3;
    logic [2:0] p;
    load_rx(32'h44332211, 5);
    rxq[4] = 8'h55;
    do_read(1'b1, p);
    chk("R3 pop", {29'h0, p}, 32'd4);
    chk("R3 data", bus_rdata, 32'h44332211);
    chk("R6 no underrun", {31'h0, rd_underrun}, 32'h0);
    @(negedge clk);
    chk("R8 held", bus_rdata, 32'h44332211);
    chk("R3 remaining", rx_n, 32'd1);
  endtask

  task automatic t_byte_read_r5;
    logic [2:0] p;
    load_rx(32'h0000A2A1, 2);
    do_read(1'b0, p);
    chk("R5 pop", {29'h0, p}, 32'd1);
    chk("R5 data", bus_rdata, 32'h000000A1);
  endtask

  task automatic t_short_read_r6;
    logic [2:0] p;
    load_rx(32'h0000C2C1, 2);
    do_read(1'b1, p);
    chk("R6 pop", {29'h0, p}, 32'd2);
    chk("R6 data", bus_rdata, 32'h0000C2C1);
    chk("R6 underrun", {31'h0, rd_underrun}, 32'h1);
    @(negedge clk);
    chk("R6 underrun pulse", {31'h0, rd_underrun}, 32'h0);
  endtask

  task automatic t_single_read_r2;
    logic [2:0] p;
    cfg_nine_bit = 1'b1;
    load_rx(32'h87868584, 4);
    do_read(1'b1, p);
    chk("R2 nine-bit pop", {29'h0, p}, 32'd1);
    chk("R2 nine-bit data", bus_rdata, 32'h00000084);
    cfg_nine_bit = 1'b0; cfg_proto = 2'd3;
    do_read(1'b1, p);
    chk("R2 LON data", bus_rdata, 32'h00000085);
    load_rx(32'h0, 0);
    do_read(1'b1, p);
    chk("R2 empty pop", {29'h0, p}, 32'd0);
    chk("R6 empty data", bus_rdata, 32'h0);
    chk("R6 empty underrun", {31'h0, rd_underrun}, 32'h1);
    cfg_proto = 2'd0;
  endtask

  task automatic t_word_write_r4;
    logic [2:0] p; logic [31:0] l;
    tx_room = 3'd4;
    do_write(1'b1, 32'hDDCCBBAA, p, l);
    chk("R4 push", {29'h0, p}, 32'd4);
    chk("R4 lanes", l, 32'hDDCCBBAA);
    chk("R4 no overflow", {31'h0, tx_overflow}, 32'h0);
  endtask

  task automatic t_single_write_r2;
    logic [2:0] p; logic [31:0] l;
    cfg_proto = 2'd1;
    do_write(1'b1, 32'h12345678, p, l);
    chk("R2 LIN push", {29'h0, p}, 32'd1);
    chk("R2 LIN lane0", {24'h0, l[7:0]}, 32'h78);
    cfg_proto = 2'd0;
    do_write(1'b0, 32'h000000EE, p, l);
    chk("R5 byte push", {29'h0, p}, 32'd1);
  endtask

  task automatic t_short_write_r7;
    logic [2:0] p; logic [31:0] l;
    tx_room = 3'd3;
    do_write(1'b1, 32'h04030201, p, l);
    chk("R7 push", {29'h0, p}, 32'd3);
    chk("R7 overflow", {31'h0, tx_overflow}, 32'h1);
    tx_room = 3'd4;
    do_write(1'b1, 32'h08070605, p, l);
    chk("R7 sticky", {31'h0, tx_overflow}, 32'h1);
  endtask

  task automatic t_idle_r10;
    load_rx(32'h11111111, 4);
    tx_room = 3'd4;
    @(negedge clk);
    chk("R10 idle pop", {29'h0, rx_pop}, 32'd0);
    chk("R10 idle push", {29'h0, tx_push}, 32'd0);
  endtask

  initial begin
    load_rx(32'h0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_r1();
    t_word_read_r3();
    t_byte_read_r5();
    t_short_read_r6();
    t_single_read_r2();
    t_word_write_r4();
    t_single_write_r2();
    t_short_write_r7();
    t_idle_r10();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule